// File: doc/BRIEF.md
# Hardwired Execute-Step Control Sequencer

This block is the hardwired control unit for a small 16-bit accumulator machine whose registers and memory hang on one shared bus. Every bus party has a 3-bit datapath address. The sequencer issues each transfer as two codes: a read code that names the party driving the bus and a write code that names the party loading from it. It also drives a 2-bit ALU mode and a counter-reset line. All of these are combinational functions of the current step strobe and the opcode in the instruction register.

A 3-bit step counter feeds a 3-to-8 decoder, which produces one-hot step strobes. Once fetch is complete, a one-cycle execute-start pulse launches the execute phase. The first strobe appears one cycle after that pulse. The counter then advances one step per clock until the decode asserts the counter reset, and the sequencer then falls idle. The execute sequences in scope cover the memory-reference add and subtract instructions. Any other opcode ends at once.

Bus codes used: memory 000, MAR 001, MBR 011, AC 100, IR 111. ALU modes: 00 no operation, 01 add, 10 subtract, 11 clear. The opcode is IR[15:12]: add is 0011 and subtract is 0100.

Top module: `ctrl_sequencer`

## Requirements
- R1: While synchronous reset is high, and in the first cycle after it falls, all step strobes, read code, write code, ALU mode and counter reset are 0.
- R2: An execute-start pulse sampled while idle makes strobe T0 (stepStrobe[0]) appear on the next cycle. The strobes are one-hot while a sequence runs and advance by one position per clock.
- R3: For add (opcode 0011) at T0, the read code is 111 (IR) and the write code is 001 (MAR). The ALU mode and counter reset are 0.
- R4: For add at T1, the read code is 000 (memory) and the write code is 011 (MBR).
- R5: For add at T2, the read code is 011 (MBR), the write code is 100 (AC) and the ALU mode is 01 (add).
- R6: At T3 of add, only the counter reset is 1. On the following cycle the sequencer is idle, with no strobe.
- R7: Subtract (opcode 0100) produces the same four steps as add, except that the ALU mode at T2 is 10.
- R8: Any other opcode asserts only the counter reset at T0. The sequencer is idle on the next cycle.
- R9: While idle, the read code, write code, ALU mode and counter reset are all 0.
- R10: An execute-start pulse that arrives while a sequence runs, including during the counter-reset step, is ignored.
- R11: Reset asserted in the middle of a sequence returns the sequencer to idle on the next cycle.
- R12: operandField always equals IR[11:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| execStart | input | 1 | One-cycle pulse that starts the execute phase |
| instrReg | input | 16 | Instruction register value |
| readSel | output | 3 | Bus source code (P2..P0) |
| writeSel | output | 3 | Bus destination code (P5..P3) |
| aluMode | output | 2 | ALU mode (A1..A0) |
| ctrReset | output | 1 | Step counter reset (Cr) |
| stepStrobe | output | 8 | One-hot step strobes T0..T7 |
| operandField | output | 12 | Operand address field of the instruction |

## Verification
The bench targets these edges:
- A start pulse placed in the counter-reset cycle must be dropped. A design that samples start there would run a second sequence.
- A start pulse in the middle of a sequence must not rewind the counter to T0, which would repeat the MAR load.
- Unknown opcodes 0000 and 1111 must end after one step. A design that decodes only the low opcode bits, or forgets the early stop, would drive bus codes or hang at later strobes.
- A reset in the middle of a sequence, and back-to-back add and subtract sequences, expose a counter that keeps stale state or an ALU mode wired to the wrong line.

// File: rtl/ctrl_seq_pkg.sv
package ctrl_seq_pkg;
  localparam int CNT_W  = 3;
  localparam int CODE_W = 3;
  localparam int MODE_W = 2;
  localparam int OPC_W  = 4;

  localparam logic [CODE_W-1:0] BUS_MEM = 3'd0;
  localparam logic [CODE_W-1:0] BUS_MAR = 3'd1;
  localparam logic [CODE_W-1:0] BUS_MBR = 3'd3;
  localparam logic [CODE_W-1:0] BUS_AC  = 3'd4;
  localparam logic [CODE_W-1:0] BUS_IR  = 3'd7;

  localparam logic [MODE_W-1:0] ALU_NOP = 2'b00;
  localparam logic [MODE_W-1:0] ALU_ADD = 2'b01;
  localparam logic [MODE_W-1:0] ALU_SUB = 2'b10;
  localparam logic [MODE_W-1:0] ALU_CLR = 2'b11;

  localparam logic [OPC_W-1:0] OPC_ADD = 4'b0011;
  localparam logic [OPC_W-1:0] OPC_SUB = 4'b0100;

  typedef struct packed {
    logic [CODE_W-1:0] readSel;
    logic [CODE_W-1:0] writeSel;
    logic [MODE_W-1:0] aluMode;
    logic              ctrReset;
  } ctrlWord_t;
endpackage

// File: rtl/step_timer.sv
module step_timer #(
  parameter int CNT_W = 3,
  localparam int NSTEP = 1 << CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             execStart,
  input  logic             ctrReset,
  output logic [NSTEP-1:0] stepStrobe
);
  logic             active;
  logic [CNT_W-1:0] stepQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      stepQ  <= '0;
    end else if (!active) begin
      if (execStart) begin
        active <= 1'b1;
        stepQ  <= '0;
      end
    end else if (ctrReset) begin
      active <= 1'b0;
      stepQ  <= '0;
    end else begin
      stepQ <= stepQ + CNT_W'(1);
    end
  end

  // 3-to-8 style decode of the step count, gated by the run flag
  for (genvar i = 0; i < NSTEP; i++) begin : gDec
    assign stepStrobe[i] = active && (stepQ == CNT_W'(i));
  end

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stepStrobe)); // R2
  AST_START_T0: assert property (@(posedge clk) disable iff (rst)
    (stepStrobe == '0 && execStart) |=> stepStrobe[0]); // R2
  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (stepStrobe != '0 && !ctrReset) |=> (stepStrobe == ($past(stepStrobe) << 1))); // R2
  AST_CR_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    ctrReset |=> (stepStrobe == '0)); // R6
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (stepStrobe != '0 && !ctrReset && execStart) |=> !stepStrobe[0]); // R10
endmodule

// File: rtl/ctrl_decode.sv
module ctrl_decode
  import ctrl_seq_pkg::*;
#(
  parameter int NSTEP = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  input  logic [NSTEP-1:0] stepStrobe,
  output ctrlWord_t        word
);
  logic isAdd, isSub, known, lateStep;

  assign isAdd    = (opcode == OPC_ADD);
  assign isSub    = (opcode == OPC_SUB);
  assign known    = isAdd | isSub;
  assign lateStep = |stepStrobe[NSTEP-1:4];

  always_comb begin
    word = '0;
    if (known) begin
      if (stepStrobe[0]) begin
        word.readSel  = BUS_IR;
        word.writeSel = BUS_MAR;
      end
      if (stepStrobe[1]) begin
        word.readSel  = BUS_MEM;
        word.writeSel = BUS_MBR;
      end
      if (stepStrobe[2]) begin
        word.readSel  = BUS_MBR;
        word.writeSel = BUS_AC;
        word.aluMode  = isAdd ? ALU_ADD : ALU_SUB;
      end
      if (stepStrobe[3] || lateStep) word.ctrReset = 1'b1;
    end else if (stepStrobe != '0) begin
      word.ctrReset = 1'b1;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (stepStrobe == '0) |-> (word == '0)); // R9
  AST_ALU_ONLY_T2: assert property (@(posedge clk) disable iff (rst)
    (word.aluMode != ALU_NOP) |-> stepStrobe[2]); // R5
  AST_ALU_NEVER_CLR: assert property (@(posedge clk) disable iff (rst)
    word.aluMode != ALU_CLR); // R7
  AST_UNKNOWN_STOP: assert property (@(posedge clk) disable iff (rst)
    (!known && stepStrobe[0]) |-> (word.ctrReset && word.readSel == '0 && word.writeSel == '0)); // R8
endmodule

// File: rtl/ctrl_sequencer.sv
module ctrl_sequencer
  import ctrl_seq_pkg::*;
#(
  parameter int IR_W   = 16,
  parameter int ADDR_W = 12,
  localparam int NSTEP = 1 << CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              execStart,
  input  logic [IR_W-1:0]   instrReg,
  output logic [CODE_W-1:0] readSel,
  output logic [CODE_W-1:0] writeSel,
  output logic [MODE_W-1:0] aluMode,
  output logic              ctrReset,
  output logic [NSTEP-1:0]  stepStrobe,
  output logic [ADDR_W-1:0] operandField
);
  ctrlWord_t word;

  step_timer #(.CNT_W(CNT_W)) uTimer (
    .clk(clk), .rst(rst), .execStart(execStart),
    .ctrReset(word.ctrReset), .stepStrobe(stepStrobe)
  );

  ctrl_decode #(.NSTEP(NSTEP)) uDecode (
    .clk(clk), .rst(rst), .opcode(instrReg[IR_W-1 -: OPC_W]),
    .stepStrobe(stepStrobe), .word(word)
  );

  assign readSel      = word.readSel;
  assign writeSel     = word.writeSel;
  assign aluMode      = word.aluMode;
  assign ctrReset     = word.ctrReset;
  assign operandField = instrReg[ADDR_W-1:0];

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (stepStrobe == '0 && ctrReset == 1'b0)); // R1
  AST_MID_RESET: assert property (@(posedge clk)
    (rst && stepStrobe != '0) |=> (readSel == '0 && writeSel == '0)); // R11
endmodule

// File: tb/ctrl_sequencer_test.sv
module ctrl_sequencer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        execStart = 1'b0;
  logic [15:0] instrReg = 16'h0000;
  logic [2:0]  readSel, writeSel;
  logic [1:0]  aluMode;
  logic        ctrReset;
  logic [7:0]  stepStrobe;
  logic [11:0] operandField;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic [16:0] expQ[$];
  string curTag = "R1";

  always #4 clk = ~clk;

  ctrl_sequencer uut (
    .clk(clk), .rst(rst), .execStart(execStart), .instrReg(instrReg),
    .readSel(readSel), .writeSel(writeSel), .aluMode(aluMode),
    .ctrReset(ctrReset), .stepStrobe(stepStrobe), .operandField(operandField)
  );

  function automatic logic [16:0] mk(int s, int r, int w, int a, int c);
    logic [7:0] t = (s < 0) ? 8'h00 : (8'h01 << s);
    return {t, 3'(r), 3'(w), 2'(a), 1'(c)};
  endfunction

  task automatic pushSeq(logic [3:0] opc);
    if (opc == 4'b0011 || opc == 4'b0100) begin
      expQ.push_back(mk(0, 7, 1, 0, 0));
      expQ.push_back(mk(1, 0, 3, 0, 0));
      expQ.push_back(mk(2, 3, 4, (opc == 4'b0011) ? 1 : 2, 0));
      expQ.push_back(mk(3, 0, 0, 0, 1));
    end else begin
      expQ.push_back(mk(0, 0, 0, 0, 1));
    end
  endtask

  // one clock: compare at the falling edge, then drive the next inputs
  task automatic tick(logic st, logic rs, logic [15:0] ir);
    logic [16:0] exp, act;
    logic idleShown;
    @(negedge clk);
    idleShown = (expQ.size() == 0);
    exp = idleShown ? 17'h0 : expQ.pop_front();
    act = {stepStrobe, readSel, writeSel, aluMode, ctrReset};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: control actual=%h expected=%h", curTag, act, exp);
    end
    total++;
    if (operandField !== instrReg[11:0]) begin // R12
      bad++;
      $display("FAIL R12: operandField actual=%h expected=%h", operandField, instrReg[11:0]);
    end
    rst = rs;
    execStart = st;
    instrReg = ir;
    if (rs) expQ.delete();
    else if (st && idleShown) pushSeq(ir[15:12]);
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<=5000", cycles);
      finishRun();
    end
  end

  initial begin
    curTag = "R1 reset";
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b1, 16'h0000);
    tick(1'b0, 1'b0, 16'h3ABC);
    curTag = "R9 idle";
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b0, 16'h3ABC);

    curTag = "R2 R3 R4 R5 R6 add";
    tick(1'b1, 1'b0, 16'h3123);
    for (int i = 0; i < 6; i++) tick(1'b0, 1'b0, 16'h3123);

    curTag = "R7 subtract";
    tick(1'b1, 1'b0, 16'h4FFF);
    for (int i = 0; i < 5; i++) tick(1'b0, 1'b0, 16'h4FFF);

    curTag = "R8 unknown 0000";
    tick(1'b1, 1'b0, 16'h0055);
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b0, 16'h0055);
    curTag = "R8 unknown 1111";
    tick(1'b1, 1'b0, 16'hF001);
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b0, 16'hF001);

    curTag = "R10 start mid-sequence";
    tick(1'b1, 1'b0, 16'h3010);
    tick(1'b0, 1'b0, 16'h3010);
    tick(1'b1, 1'b0, 16'h3010);
    tick(1'b0, 1'b0, 16'h3010);
    tick(1'b1, 1'b0, 16'h3010);
    for (int i = 0; i < 4; i++) tick(1'b0, 1'b0, 16'h3010);

    curTag = "R2 back-to-back";
    tick(1'b1, 1'b0, 16'h4002);
    for (int i = 0; i < 4; i++) tick(1'b0, 1'b0, 16'h4002);
    tick(1'b1, 1'b0, 16'h3003);
    for (int i = 0; i < 5; i++) tick(1'b0, 1'b0, 16'h3003);

    curTag = "R11 reset mid-sequence";
    tick(1'b1, 1'b0, 16'h4777);
    tick(1'b0, 1'b0, 16'h4777);
    tick(1'b0, 1'b1, 16'h4777);
    tick(1'b0, 1'b0, 16'h4777);
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b0, 16'h4777);

    finishRun();
  end
endmodule